// File: doc/BRIEF.md
# String Operand Validity Tagger

This block marks which elements of two packed string operands hold real string data. It also raises an end-of-string indication for each operand. Each operand is a 128-bit lane holding sixteen bytes or eight 16-bit words. Validity comes from one of two sources, and a single mode input picks which one.

In length mode, each operand comes with a signed length of 32 or 64 bits. The block takes the magnitude of that length and clamps it to the element count. The elements below that count are valid. In terminator mode, the data is scanned for its lowest zero element. Every element below that zero element is valid, and the zero element and everything above it are invalid.

The registered masks and end flags feed the comparison aggregator and the flag logic further down the pipeline. Results appear one clock after the inputs are presented.

Top module: `str_valid_tagger`

## Requirements
- R1: In length mode (`use_length`=1), the effective length n is the magnitude of the signed length. Bit i of an operand's mask is 1 exactly when i < n. A zero length gives an all-zero mask.
- R2: The effective length clamps to 16 for bytes (`word_elems`=0) and 8 for words (`word_elems`=1) whenever the magnitude exceeds that count. This holds for positive and negative lengths, and for the most negative value of either width.
- R3: With `len_wide`=0, only bits [31:0] of a length input are used, read as a signed 32-bit value. Bits [63:32] have no effect. With `len_wide`=1, all 64 bits are read as signed.
- R4: In terminator mode (`use_length`=0), bit i of the mask is 1 exactly when no element at index i or below is zero. The lowest zero element is invalid, and so is every element above it.
- R5: In length mode, an operand's end flag is 1 exactly when its effective length is below the element count (16 or 8).
- R6: In terminator mode, an operand's end flag is 1 exactly when any element of that operand is zero.
- R7: In word mode, an element is zero only when all 16 of its bits are zero. A word with only one zero byte is not a terminator. Mask bits [15:8] are always 0 in word mode.
- R8: Masks and end flags are registered with a latency of one clock. While `rst_n` is low they read 0.
- R9: In length mode the data inputs have no effect on the outputs. In terminator mode the length inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_length | input | 1 | 1: validity from the length inputs; 0: validity from the first zero element |
| word_elems | input | 1 | 0: sixteen 8-bit elements; 1: eight 16-bit elements |
| len_wide | input | 1 | 0: lengths are signed 32-bit in bits [31:0]; 1: lengths are signed 64-bit |
| len_a | input | 64 | Signed length of operand A |
| len_b | input | 64 | Signed length of operand B |
| data_a | input | 128 | Packed elements of operand A |
| data_b | input | 128 | Packed elements of operand B |
| mask_a | output | 16 | Valid mask of operand A, bit i for element i |
| mask_b | output | 16 | Valid mask of operand B |
| end_a | output | 1 | End-of-string indication of operand A |
| end_b | output | 1 | End-of-string indication of operand B |

## Verification
Length mode is tried with every length from -20 to +20, in both element sizes and both length widths. Operand B always gets the negated length, so the sweep separates correct magnitude handling from sign mishandling and places both sides of each clamp boundary. Separate cases cover the extreme values, where a wrapping absolute value would show up. Other cases put nonzero upper halves into 32-bit lengths, which shows whether bits [63:32] leak into the result.

Terminator mode places a single zero element at every position from 0 to past the last element. A second, later zero is added as well, which tells a lowest-zero scan apart from a highest-zero scan. Word mode uses words with one zero byte, which catches byte-granular zero detection. Data and lengths are filled with misleading values in the mode that should ignore them.

// File: rtl/str_tag_pkg.sv
package str_tag_pkg;
  typedef enum logic {
    TERM_NULL   = 1'b0,
    TERM_LENGTH = 1'b1
  } term_src_e;

  typedef enum logic {
    ELEM_BYTE = 1'b0,
    ELEM_WORD = 1'b1
  } elem_size_e;
endpackage

// File: rtl/stv_len_unit.sv
module stv_len_unit #(
  parameter int LANE_W   = 128,
  parameter int LEN_W    = 64,
  parameter int NARROW_W = 32,
  localparam int BYTE_N  = LANE_W / 8,
  localparam int WORD_N  = LANE_W / 16,
  localparam int CNT_W   = $clog2(BYTE_N + 1)
) (
  input  logic [LEN_W-1:0] len_raw,
  input  logic             len_wide,
  input  logic             word_mode,
  output logic [CNT_W-1:0] eff_len,
  output logic [CNT_W-1:0] elem_cap,
  output logic             short_o
);
  // sign-extend the narrow form when only the low half is meaningful
  function automatic logic [LEN_W-1:0] f_extend(input logic [LEN_W-1:0] raw, input logic wide);
    if (wide) return raw;
    return {{(LEN_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
  endfunction

  // magnitude carried one bit wider so the most negative value cannot wrap
  function automatic logic [LEN_W:0] f_magnitude(input logic [LEN_W-1:0] v);
    if (v[LEN_W-1]) return {1'b0, ~v} + {{LEN_W{1'b0}}, 1'b1};
    return {1'b0, v};
  endfunction

  logic [LEN_W-1:0] len_ext;
  logic [LEN_W:0]   len_mag;
  logic [LEN_W:0]   cap_wide;

  always_comb begin
    len_ext  = f_extend(len_raw, len_wide);
    len_mag  = f_magnitude(len_ext);
    elem_cap = word_mode ? CNT_W'(WORD_N) : CNT_W'(BYTE_N);
    cap_wide = {{(LEN_W+1-CNT_W){1'b0}}, elem_cap};
    eff_len  = (len_mag > cap_wide) ? elem_cap : len_mag[CNT_W-1:0];
    short_o  = (eff_len < elem_cap);
  end
endmodule

// File: rtl/stv_null_scan.sv
module stv_null_scan #(
  parameter int LANE_W  = 128,
  localparam int BYTE_N = LANE_W / 8,
  localparam int WORD_N = LANE_W / 16
) (
  input  logic [LANE_W-1:0] data,
  input  logic              word_mode,
  output logic [BYTE_N-1:0] elem_null,
  output logic [BYTE_N-1:0] prefix_mask,
  output logic              has_null
);
  logic [BYTE_N-1:0] byte_zero;
  logic [WORD_N-1:0] word_zero;

  for (genvar b = 0; b < BYTE_N; b++) begin : g_byte
    assign byte_zero[b] = (data[8*b +: 8] == 8'h00);
  end

  for (genvar w = 0; w < WORD_N; w++) begin : g_word
    assign word_zero[w] = (data[16*w +: 16] == 16'h0000);
  end

  // unused upper slots in word mode are padded as terminators so the
  // prefix mask stays clear there
  always_comb begin
    elem_null = word_mode ? {{(BYTE_N-WORD_N){1'b1}}, word_zero} : byte_zero;
    has_null  = word_mode ? (|word_zero) : (|byte_zero);
  end

  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < BYTE_N; i++) begin
      run            = run & ~elem_null[i];
      prefix_mask[i] = run;
    end
  end
endmodule

// File: rtl/stv_operand.sv
module stv_operand
  import str_tag_pkg::*;
#(
  parameter int LANE_W   = 128,
  parameter int LEN_W    = 64,
  parameter int NARROW_W = 32,
  localparam int BYTE_N  = LANE_W / 8,
  localparam int WORD_N  = LANE_W / 16,
  localparam int CNT_W   = $clog2(BYTE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  term_src_e         term_src,
  input  elem_size_e        elem_size,
  input  logic              len_wide,
  input  logic [LEN_W-1:0]  len_raw,
  input  logic [LANE_W-1:0] data,
  output logic [BYTE_N-1:0] mask_q,
  output logic              end_q
);
  localparam logic [BYTE_N-1:0] FULL_BYTE = {BYTE_N{1'b1}};
  localparam logic [BYTE_N-1:0] FULL_WORD = {{(BYTE_N-WORD_N){1'b0}}, {WORD_N{1'b1}}};

  logic              word_mode;
  logic [CNT_W-1:0]  eff_len;
  logic [CNT_W-1:0]  elem_cap;
  logic              len_short;
  logic [BYTE_N-1:0] len_mask;
  logic [BYTE_N-1:0] elem_null;
  logic [BYTE_N-1:0] scan_mask;
  logic              scan_hit;
  logic [BYTE_N-1:0] mask_d;
  logic              end_d;
  logic              word_q;
  logic              primed_q;
  logic              len_sel;

  assign word_mode = (elem_size == ELEM_WORD);
  assign len_sel   = (term_src == TERM_LENGTH);

  stv_len_unit #(.LANE_W(LANE_W), .LEN_W(LEN_W), .NARROW_W(NARROW_W)) u_len (
    .len_raw  (len_raw),
    .len_wide (len_wide),
    .word_mode(word_mode),
    .eff_len  (eff_len),
    .elem_cap (elem_cap),
    .short_o  (len_short)
  );

  stv_null_scan #(.LANE_W(LANE_W)) u_scan (
    .data       (data),
    .word_mode  (word_mode),
    .elem_null  (elem_null),
    .prefix_mask(scan_mask),
    .has_null   (scan_hit)
  );

  for (genvar i = 0; i < BYTE_N; i++) begin : g_lenmask
    assign len_mask[i] = (CNT_W'(i) < eff_len);
  end

  always_comb begin
    mask_d = len_sel ? len_mask  : scan_mask;
    end_d  = len_sel ? len_short : scan_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      end_q    <= 1'b0;
      word_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      end_q    <= end_d;
      word_q   <= word_mode;
      primed_q <= 1'b1;
    end
  end

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    eff_len <= elem_cap);  // R2

  AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & (mask_q + 1'b1)) == '0);  // R4

  AST_WORD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    word_q |-> (mask_q[BYTE_N-1:WORD_N] == '0));  // R7

  AST_END_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (end_q == (mask_q != (word_q ? FULL_WORD : FULL_BYTE))));  // R5

  AST_ZERO_LENGTH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (len_sel && eff_len == '0) |=> (mask_q == '0));  // R1

  AST_NULL_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!len_sel && elem_null[0]) |=> (mask_q == '0 && end_q));  // R6
endmodule

// File: rtl/str_valid_tagger.sv
module str_valid_tagger
  import str_tag_pkg::*;
#(
  parameter int LANE_W   = 128,
  parameter int LEN_W    = 64,
  parameter int NARROW_W = 32,
  localparam int BYTE_N  = LANE_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_length,
  input  logic              word_elems,
  input  logic              len_wide,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  input  logic [LANE_W-1:0] data_a,
  input  logic [LANE_W-1:0] data_b,
  output logic [BYTE_N-1:0] mask_a,
  output logic [BYTE_N-1:0] mask_b,
  output logic              end_a,
  output logic              end_b
);
  term_src_e  term_src;
  elem_size_e elem_size;

  assign term_src  = term_src_e'(use_length);
  assign elem_size = elem_size_e'(word_elems);

  stv_operand #(.LANE_W(LANE_W), .LEN_W(LEN_W), .NARROW_W(NARROW_W)) u_op_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .term_src (term_src),
    .elem_size(elem_size),
    .len_wide (len_wide),
    .len_raw  (len_a),
    .data     (data_a),
    .mask_q   (mask_a),
    .end_q    (end_a)
  );

  stv_operand #(.LANE_W(LANE_W), .LEN_W(LEN_W), .NARROW_W(NARROW_W)) u_op_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .term_src (term_src),
    .elem_size(elem_size),
    .len_wide (len_wide),
    .len_raw  (len_b),
    .data     (data_b),
    .mask_q   (mask_b),
    .end_q    (end_b)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (mask_a == '0 && mask_b == '0 && !end_a && !end_b));  // R8
endmodule

// File: tb/tb_str_valid_tagger.sv
`timescale 1ns/1ps
module tb_str_valid_tagger;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         use_length = 1'b0;
  logic         word_elems = 1'b0;
  logic         len_wide = 1'b0;
  logic [63:0]  len_a = '0, len_b = '0;
  logic [127:0] data_a = '0, data_b = '0;
  logic [15:0]  mask_a, mask_b;
  logic         end_a, end_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  str_valid_tagger dut (
    .clk(clk), .rst_n(rst_n), .use_length(use_length), .word_elems(word_elems),
    .len_wide(len_wide), .len_a(len_a), .len_b(len_b), .data_a(data_a),
    .data_b(data_b), .mask_a(mask_a), .mask_b(mask_b), .end_a(end_a), .end_b(end_b)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int model_len(input logic [63:0] l, input bit wide, input bit word);
    longint v;
    int cap;
    cap = word ? 8 : 16;
    v = wide ? longint'($signed(l)) : longint'($signed(l[31:0]));
    if (v >= cap || v <= -cap) return cap;
    return (v < 0) ? int'(-v) : int'(v);
  endfunction

  function automatic logic [15:0] ones(input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int model_scan(input logic [127:0] d, input bit word);
    int cnt = word ? 8 : 16;
    for (int i = 0; i < cnt; i++) begin
      if (word ? (d[16*i +: 16] == 16'h0) : (d[8*i +: 8] == 8'h0)) return i;
    end
    return cnt;
  endfunction

  task automatic apply(input bit ul, input bit wd, input bit wide,
                       input logic [63:0] la, input logic [63:0] lb,
                       input logic [127:0] da, input logic [127:0] db, input string tag);
    int na, nb, cnt;
    @(negedge clk);
    use_length = ul; word_elems = wd; len_wide = wide;
    len_a = la; len_b = lb; data_a = da; data_b = db;
    @(negedge clk);
    cnt = wd ? 8 : 16;
    if (ul) begin
      na = model_len(la, wide, wd);
      nb = model_len(lb, wide, wd);
    end else begin
      na = model_scan(da, wd);
      nb = model_scan(db, wd);
    end
    check({tag, " mask_a"}, mask_a, ones(na));
    check({tag, " mask_b"}, mask_b, ones(nb));
    check({tag, " end_a"}, {15'd0, end_a}, {15'd0, na < cnt});
    check({tag, " end_b"}, {15'd0, end_b}, {15'd0, nb < cnt});
  endtask

  function automatic logic [127:0] fill(input bit word, input int zpos, input int zpos2);
    logic [127:0] d;
    for (int i = 0; i < 8; i++) d[16*i +: 16] = (i % 2 == 0) ? 16'h4100 : 16'h0041;
    if (!word) for (int i = 0; i < 16; i++) d[8*i +: 8] = 8'h5A;
    if (word) begin
      if (zpos < 8) d[16*zpos +: 16] = 16'h0;
      if (zpos2 < 8) d[16*zpos2 +: 16] = 16'h0;
    end else begin
      if (zpos < 16) d[8*zpos +: 8] = 8'h0;
      if (zpos2 < 16) d[8*zpos2 +: 8] = 8'h0;
    end
    return d;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset mask_a", mask_a, 16'h0);
    check("R8 reset mask_b", mask_b, 16'h0);
    check("R8 reset end", {14'd0, end_a, end_b}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R5: length sweep, both widths and sizes; R9 data has zeros
    for (int wide = 0; wide < 2; wide++)
      for (int wd = 0; wd < 2; wd++)
        for (int l = -20; l <= 20; l++) begin
          longint lv = l;
          apply(1'b1, wd[0], wide[0], 64'(lv), 64'(-lv), '0, fill(wd[0], 0, 3),
                "R1 R2 R5 R9 length sweep");
        end

    // R2: extremes that a wrapping magnitude would break
    apply(1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, '0, '0, "R2 min64");
    apply(1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF9, '0, '0, "R2 min64 word");
    apply(1'b1, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFF1, '0, '0, "R2 min32");
    // R3: upper halves ignored in 32-bit, honoured in 64-bit
    apply(1'b1, 1'b0, 1'b0, 64'h0000_0001_0000_0003, 64'hDEAD_BEEF_FFFF_FFFB, '0, '0, "R3 narrow");
    apply(1'b1, 1'b0, 1'b1, 64'h0000_0001_0000_0003, 64'hFFFF_FFFF_FFFF_FFFB, '0, '0, "R3 wide");
    apply(1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0006, 64'h0000_0000_0000_0000, '0, '0, "R3 narrow word");

    // R4 R6 R7: zero element swept over every position, second zero later
    for (int wd = 0; wd < 2; wd++) begin
      int cnt = wd ? 8 : 16;
      for (int p = 0; p <= cnt; p++)
        apply(1'b0, wd[0], 1'b0, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF,
              fill(wd[0], p, p + 2), fill(wd[0], cnt - 1 - p, cnt),
              wd ? "R4 R6 R7 R9 word scan" : "R4 R6 R9 byte scan");
    end
    // R7: half-zero words are not terminators
    apply(1'b0, 1'b1, 1'b0, '0, '0, {8{16'h0100}}, {8{16'h00FF}}, "R7 half-zero words");

    // R8: reset clears outputs again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 re-reset mask_a", mask_a, 16'h0);
    check("R8 re-reset end", {14'd0, end_a, end_b}, 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule